// File: doc/BRIEF.md
# Translation Cache with Line Shootdown

This block is a small fully-associative cache of address translations. Each slot holds a virtual page number and the leaf page-table entry that maps it. A table walker or similar agent writes translations in through a fill port. Clients look up a page number and receive a one-cycle hit or miss strobe. On a hit, the cached entry comes back with the strobe. When a fill brings in a page number that is not yet cached, it takes the slot chosen by a round-robin pointer. When the page number is already cached, the fill overwrites that entry in place.

Two invalidation commands keep the cache coherent with the page tables in memory. A full clear drops every entry. A shootdown drops only the entries inside one naturally aligned line of four consecutive pages. Both commands step through the slots one per cycle, and each shows its own busy flag for as long as it runs. Software issues a command and then polls the matching busy flag until it reads zero. While either command runs, lookups report a miss and new fills and commands are not accepted.

Top module: `tlb_shoot`

## Requirements
- R1: After reset every slot is empty, both busy flags are low, no strobe is raised, and the first lookup misses.
- R2: A lookup sampled on one clock edge raises exactly one of `lk_hit` or `lk_miss` for one cycle after that edge. On a hit, `lk_pte` carries the entry stored for that page number.
- R3: A fill of an uncached page number writes the slot under the round-robin pointer. The pointer then advances by one, wrapping after the last slot, so the seventeenth distinct fill evicts the first.
- R4: A fill of a page number that is already cached replaces that slot's entry and leaves the pointer where it was.
- R5: A shootdown invalidates exactly the cached pages whose number matches the command's page number in all bits above bits 1..0. Bits 1..0 of the command are ignored. All other entries survive.
- R6: `sd_busy` rises on the edge that accepts a shootdown and stays high for exactly 16 cycles (one per slot).
- R7: A full clear invalidates every slot. `clr_busy` stays high for exactly 16 cycles after the accepting edge.
- R8: A lookup sampled while either busy flag is high reports a miss, even for a page that is cached.
- R9: Fills, clears and shootdowns presented while either busy flag is high are ignored.
- R10: When a clear and a shootdown are requested on the same idle edge, only the clear starts.
- R11: A lookup and a fill on the same edge see the cache contents from before the fill. The filled entry hits from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 24 | Page number to look up |
| lk_hit | output | 1 | Lookup hit strobe |
| lk_miss | output | 1 | Lookup miss strobe |
| lk_pte | output | 32 | Entry returned on a hit |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | 24 | Page number being filled |
| fl_pte | input | 32 | Entry being filled |
| clr_req | input | 1 | Full clear command |
| clr_busy | output | 1 | Full clear in progress |
| sd_req | input | 1 | Shootdown command |
| sd_vpn | input | 24 | Page number selecting the four-page line |
| sd_busy | output | 1 | Shootdown in progress |

## Verification
The properties assume only that reset is applied before the first request. Commands may arrive at any time, because the block itself drops any command it sees while busy. The stimulus follows the polling discipline and waits for busy to clear before the next command. The one exception is a deliberate stretch that sends a lookup, a fill and a clear into a running shootdown, to exercise the busy-time rules. Each request is held for a single cycle and driven on the falling edge, so the block samples every request exactly once.

// File: rtl/tlb_shoot_pkg.sv
package tlb_shoot_pkg;
    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_CLEAR = 2'd1,
        WALK_SHOOT = 2'd2
    } walk_mode_e;

    // mask that keeps only the page-number bits above the line offset
    function automatic logic [63:0] line_mask(input int vpn_w, input int lsb);
        logic [63:0] m;
        m = '0;
        for (int b = 0; b < 64; b++) begin
            if (b >= lsb && b < vpn_w) m[b] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N     = 16,
    parameter int VPN_W = 24,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]        key,
    output logic                    found,
    output logic [IDX_W-1:0]        idx
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        found = |hit_vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
    import tlb_shoot_pkg::*;
#(
    parameter int N     = 16,
    parameter int VPN_W = 24,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_req,
    input  logic             sd_req,
    input  logic [VPN_W-1:0] sd_vpn,
    output logic             clr_busy,
    output logic             sd_busy,
    output logic             step_en,
    output logic             step_all,
    output logic [IDX_W-1:0] step_idx,
    output logic [VPN_W-1:0] step_vpn
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    typedef struct packed {
        walk_mode_e       mode;
        logic [IDX_W-1:0] idx;
        logic [VPN_W-1:0] vpn;
    } walk_t;

    walk_t d, q;

    always_comb begin
        d = q;
        if (q.mode == WALK_IDLE) begin
            if (clr_req) begin
                d.mode = WALK_CLEAR;
                d.idx  = '0;
            end else if (sd_req) begin
                d.mode = WALK_SHOOT;
                d.idx  = '0;
                d.vpn  = sd_vpn;
            end
        end else begin
            if (q.idx == LAST) begin
                d.mode = WALK_IDLE;
                d.idx  = '0;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode <= WALK_IDLE;
            q.idx  <= '0;
            q.vpn  <= '0;
        end else begin
            q <= d;
        end
    end

    assign clr_busy = (q.mode == WALK_CLEAR);
    assign sd_busy  = (q.mode == WALK_SHOOT);
    assign step_en  = (q.mode != WALK_IDLE);
    assign step_all = (q.mode == WALK_CLEAR);
    assign step_idx = q.idx;
    assign step_vpn = q.vpn;
endmodule

// File: rtl/tlb_shoot.sv
module tlb_shoot
    import tlb_shoot_pkg::*;
#(
    parameter int N        = 16,
    parameter int VPN_W    = 24,
    parameter int PTE_W    = 32,
    parameter int LINE_LSB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PTE_W-1:0] lk_pte,
    input  logic             fl_valid,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PTE_W-1:0] fl_pte,
    input  logic             clr_req,
    output logic             clr_busy,
    input  logic             sd_req,
    input  logic [VPN_W-1:0] sd_vpn,
    output logic             sd_busy
);
    localparam int IDX_W = $clog2(N);
    localparam logic [VPN_W-1:0] LMASK = VPN_W'(line_mask(VPN_W, LINE_LSB));
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(N - 1);

    typedef struct packed {
        logic [N-1:0]            valid;
        logic [N-1:0][VPN_W-1:0] vpn;
        logic [N-1:0][PTE_W-1:0] pte;
        logic [IDX_W-1:0]        rr;
        logic                    hit;
        logic                    miss;
        logic [PTE_W-1:0]        pte_out;
    } cache_t;

    cache_t d, q;

    logic             lk_found, fl_found;
    logic [IDX_W-1:0] lk_idx, fl_idx;
    logic             step_en, step_all;
    logic [IDX_W-1:0] step_idx;
    logic [VPN_W-1:0] step_vpn;
    logic             busy;

    tlb_match #(.N(N), .VPN_W(VPN_W)) u_lk_match (
        .valid (q.valid),
        .tags  (q.vpn),
        .key   (lk_vpn),
        .found (lk_found),
        .idx   (lk_idx)
    );

    tlb_match #(.N(N), .VPN_W(VPN_W)) u_fl_match (
        .valid (q.valid),
        .tags  (q.vpn),
        .key   (fl_vpn),
        .found (fl_found),
        .idx   (fl_idx)
    );

    tlb_walker #(.N(N), .VPN_W(VPN_W)) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_req  (clr_req),
        .sd_req   (sd_req),
        .sd_vpn   (sd_vpn),
        .clr_busy (clr_busy),
        .sd_busy  (sd_busy),
        .step_en  (step_en),
        .step_all (step_all),
        .step_idx (step_idx),
        .step_vpn (step_vpn)
    );

    assign busy = clr_busy | sd_busy;

    always_comb begin
        d      = q;
        d.hit  = 1'b0;
        d.miss = 1'b0;

        // lookup sees the contents before any fill on this edge
        if (lk_valid) begin
            if (lk_found && !busy) begin
                d.hit     = 1'b1;
                d.pte_out = q.pte[lk_idx];
            end else begin
                d.miss = 1'b1;
            end
        end

        if (fl_valid && !busy) begin
            if (fl_found) begin
                d.pte[fl_idx] = fl_pte;
            end else begin
                d.valid[q.rr] = 1'b1;
                d.vpn[q.rr]   = fl_vpn;
                d.pte[q.rr]   = fl_pte;
                d.rr          = (q.rr == LAST) ? '0 : q.rr + 1'b1;
            end
        end

        // invalidation step: one slot per cycle
        if (step_en) begin
            if (step_all || (((q.vpn[step_idx] ^ step_vpn) & LMASK) == '0)) begin
                d.valid[step_idx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign lk_hit  = q.hit;
    assign lk_miss = q.miss;
    assign lk_pte  = q.pte_out;
endmodule

// File: rtl/tlb_shoot_chk.sv
module tlb_shoot_chk #(
    parameter int N = 16
) (
    input logic clk,
    input logic rst_n,
    input logic lk_valid,
    input logic lk_hit,
    input logic lk_miss,
    input logic clr_req,
    input logic sd_req,
    input logic clr_busy,
    input logic sd_busy
);
    localparam int CW = $clog2(N) + 2;
    logic          any_busy;
    logic [CW-1:0] cnt_q;

    assign any_busy = clr_busy | sd_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (any_busy) cnt_q <= cnt_q + 1'b1;
        else               cnt_q <= '0;
    end

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    p_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (lk_hit || lk_miss));

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(lk_hit || lk_miss));

    p_busy_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && any_busy) |=> lk_miss);

    p_one_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_busy && sd_busy));

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !any_busy) |=> (clr_busy && !sd_busy));

    p_shoot_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_req && !clr_req && !any_busy) |=> sd_busy);

    p_walk_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_busy) |-> (cnt_q == CW'(N)));

    p_walk_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_busy |-> (cnt_q < CW'(N)));
endmodule

bind tlb_shoot tlb_shoot_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_hit   (lk_hit),
    .lk_miss  (lk_miss),
    .clr_req  (clr_req),
    .sd_req   (sd_req),
    .clr_busy (clr_busy),
    .sd_busy  (sd_busy)
);

// File: tb/tlb_shoot_test.sv
module tlb_shoot_test;
    localparam int N = 16, VPN_W = 24, PTE_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic             lk_valid = 1'b0, fl_valid = 1'b0, clr_req = 1'b0, sd_req = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0, fl_vpn = '0, sd_vpn = '0;
    logic [PTE_W-1:0] fl_pte = '0;
    logic             lk_hit, lk_miss, clr_busy, sd_busy;
    logic [PTE_W-1:0] lk_pte;

    tlb_shoot #(.N(N), .VPN_W(VPN_W), .PTE_W(PTE_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pte(lk_pte),
        .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_pte(fl_pte),
        .clr_req(clr_req), .clr_busy(clr_busy),
        .sd_req(sd_req), .sd_vpn(sd_vpn), .sd_busy(sd_busy)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct packed {
        logic             hit;
        logic [PTE_W-1:0] pte;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    function automatic logic [PTE_W-1:0] pte_of(input logic [VPN_W-1:0] v);
        return {8'h5A, v};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each lookup strobe
    always @(negedge clk) begin
        if (rst_n && (lk_hit || lk_miss)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected strobe", {lk_hit, lk_miss}, 0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(lk_hit == e.hit && lk_miss == !e.hit && (!e.hit || lk_pte == e.pte),
                    t, {lk_hit, lk_pte}, {e.hit, e.pte});
            end
        end
    end

    task automatic lookup(input logic [VPN_W-1:0] v, input bit hit, input logic [PTE_W-1:0] p, input string tag);
        lk_valid = 1'b1;
        lk_vpn   = v;
        exp_q.push_back('{hit: hit, pte: p});
        tag_q.push_back(tag);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [VPN_W-1:0] v, input logic [PTE_W-1:0] p);
        fl_valid = 1'b1;
        fl_vpn   = v;
        fl_pte   = p;
        @(negedge clk);
        fl_valid = 1'b0;
    endtask

    task automatic shoot(input logic [VPN_W-1:0] v);
        sd_req = 1'b1;
        sd_vpn = v;
        @(negedge clk);
        sd_req = 1'b0;
    endtask

    task automatic wipe();
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (clr_busy || sd_busy) @(negedge clk);
    endtask

    task automatic finish_up();
        chk(exp_q.size() == 0, "R2 missing strobes", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!clr_busy && !sd_busy && !lk_hit && !lk_miss, "R1 reset outputs",
            {clr_busy, sd_busy, lk_hit, lk_miss}, 0);
        lookup(24'h000005, 1'b0, '0, "R1 first lookup misses");

        // R2 R3 fill all slots and read back
        for (int i = 0; i < N; i++) fill(24'h000100 + 24'(i), pte_of(24'h000100 + 24'(i)));
        for (int i = 0; i < N; i++) lookup(24'h000100 + 24'(i), 1'b1, pte_of(24'h000100 + 24'(i)), "R2 R3 hit after fill");

        // R11 lookup and fill on the same edge; R3 wrap evicts slot 0
        lk_valid = 1'b1; lk_vpn = 24'h000200;
        exp_q.push_back('{hit: 1'b0, pte: '0}); tag_q.push_back("R11 same-edge lookup misses");
        fill(24'h000200, pte_of(24'h000200));
        lk_valid = 1'b0;
        lookup(24'h000200, 1'b1, pte_of(24'h000200), "R11 filled entry hits next");
        lookup(24'h000100, 1'b0, '0, "R3 seventeenth fill evicts first");

        // R4 refill in place keeps the pointer (now at slot 1)
        fill(24'h000101, 32'hDEAD0101);
        lookup(24'h000101, 1'b1, 32'hDEAD0101, "R4 refill replaces entry");
        fill(24'h000300, pte_of(24'h000300));
        lookup(24'h000101, 1'b0, '0, "R4 pointer not advanced by refill");
        lookup(24'h000102, 1'b1, pte_of(24'h000102), "R4 neighbour slot kept");

        // R5 R6 shootdown with nonzero low bits
        shoot(24'h00010D);
        n = 0;
        while (sd_busy) begin n++; @(negedge clk); end
        chk(n == N, "R6 shootdown busy length", n, N);
        for (int i = 12; i < 16; i++) lookup(24'h000100 + 24'(i), 1'b0, '0, "R5 line entries dropped");
        lookup(24'h00010B, 1'b1, pte_of(24'h00010B), "R5 entry below line kept");
        lookup(24'h000108, 1'b1, pte_of(24'h000108), "R5 other line kept");
        lookup(24'h000300, 1'b1, pte_of(24'h000300), "R5 unrelated entry kept");

        // R8 R9 activity during a running shootdown
        shoot(24'h000202);
        lookup(24'h000102, 1'b0, '0, "R8 lookup while busy misses");
        fill(24'h000400, pte_of(24'h000400));
        wipe();
        chk(!clr_busy && sd_busy, "R9 clear ignored while busy", {clr_busy, sd_busy}, 1);
        wait_idle();
        lookup(24'h000200, 1'b0, '0, "R5 shot page gone");
        lookup(24'h000102, 1'b1, pte_of(24'h000102), "R9 clear had no effect");
        lookup(24'h000400, 1'b0, '0, "R9 fill while busy ignored");

        // R10 R7 clear and shootdown together
        fill(24'h000500, pte_of(24'h000500));
        clr_req = 1'b1; sd_req = 1'b1; sd_vpn = 24'h000500;
        @(negedge clk);
        clr_req = 1'b0; sd_req = 1'b0;
        chk(clr_busy && !sd_busy, "R10 clear wins", {clr_busy, sd_busy}, 2);
        n = 0;
        while (clr_busy) begin n++; @(negedge clk); end
        chk(n == N, "R7 clear busy length", n, N);
        lookup(24'h000102, 1'b0, '0, "R7 clear drops entry");
        lookup(24'h000500, 1'b0, '0, "R7 clear drops newest entry");
        lookup(24'h000300, 1'b0, '0, "R7 clear drops all");

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule